// File: doc/BRIEF.md
# CAS-before-RAS Refresh and Power-up Engine

This block keeps a DRAM array alive. After reset it holds every strobe inactive through a power-up pause. It then issues a burst of CAS-before-RAS initialization cycles, with no handshake, and raises `ready` once the last of them has completed. From then on an interval timer marks each point at which one refresh row is due. The block asks the access sequencer for the bus. When the bus is granted, it drives one CAS-before-RAS cycle on every RAS and CAS line at once while keeping WE high. The DRAM's internal row counter picks the row, so no address is driven. If a second interval expires while a refresh is still waiting for the bus, a sticky `overrun` flag is set.

The controller is a single state machine. `ST_PAUSE` waits out the power-up time and then moves to `ST_CSR`. `ST_CSR` holds CAS low with RAS high and moves to `ST_CHR`. `ST_CHR` holds both strobes low and moves to `ST_RASH`. `ST_RASH` keeps RAS low with CAS high again and moves to `ST_PRE`. `ST_PRE` holds all strobes high. At the end of `ST_PRE` there are three possible transitions:
- back to `ST_CSR` while init cycles remain;
- to `ST_IDLE` with `ready` set after the last init cycle;
- to `ST_IDLE` after a normal refresh.

`ST_IDLE` moves to `ST_CSR` when a refresh is pending and the grant is high.

Top module: `rfs_cbr_refresh_top`

Cycle counts below use f = `CLK_MHZ` and ceil(t) = ceil(t_ns * f / 1000). Strobes are active low. All RAS lines share one value and all CAS lines share one value.

## Requirements
- R1: While reset is held and on the first cycle after it, every RAS and CAS line and WE read 1, and `ready`, `ref_req` and `overrun` read 0.
- R2: After reset, no strobe goes low for PAUSE_US*f cycles. The first CAS fall appears exactly PAUSE_US*f clock edges after reset is released.
- R3: Exactly INIT_CYCLES refresh cycles follow the pause back to back, with `ref_req` low and no grant needed. `ready` rises on the edge that ends the last precharge, which is INIT_CYCLES*L edges after the first CAS fall, where L is the cycle length from R5.
- R4: In every refresh cycle CAS goes low ceil(10) cycles before RAS falls, and CAS stays low ceil(10) cycles after RAS falls. CAS is low at the RAS fall.
- R5: RAS stays low ceil(60) cycles. Precharge lasts max(ceil(40), ceil(110) - ceil(60)) cycles. RAS is high for at least 40 ns between falls, and RAS falls are at least 110 ns apart. L = CAS lead + RAS low + precharge.
- R6: All RAS lines and all CAS lines switch together, and WE is high whenever RAS falls.
- R7: Once ready, a refresh falls due every floor(REF_WINDOW_NS/ROWS)*f/1000 cycles. `ref_req` first rises that many edges after `ready` rises. With the grant held high, RAS falls are exactly that many cycles apart.
- R8: After `ready`, `ref_req` stays high while the grant is low, and no strobe moves while no request is open.
- R9: A refresh starts with CAS falling on the first edge at which `ref_req` and `ref_gnt` are both high. `ref_req` stays high through the cycle and drops L edges after that start edge. The sequencer holds the grant until `ref_req` drops.
- R10: If the interval expires again while a refresh is still waiting, `overrun` becomes 1. It stays 1 until reset, and it stays 0 while every refresh is granted in time.
- R11: Once `ready` is 1 it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_gnt | input | 1 | Bus granted to the refresh engine by the access sequencer |
| ref_req | output | 1 | Refresh bus request |
| ras_n | output | NUM_RAS | Row strobes, active low |
| cas_n | output | NUM_CAS | Column strobes, active low |
| we_n | output | 1 | Write enable, active low, held high |
| ready | output | 1 | Array initialized; normal accesses permitted |
| overrun | output | 1 | Sticky missed-refresh flag |

## Verification
The bench measures every strobe phase in clock cycles from the outside. A machine that dropped RAS and CAS together, or released CAS at the RAS fall, would show a lead or overlap count of 0 or 1 instead of 3. A pause or interval counter that is off by one edge would move the first CAS fall, the `ready` edge or the request edge by one cycle against the computed counts. The bench holds the grant low across two interval expiries to catch an overrun flag that never sets or that clears when the late refresh is finally serviced. It also checks that a grant arriving in the middle of a wait starts the cycle on the very next edge.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_CSR,
        ST_CHR,
        ST_RASH,
        ST_PRE,
        ST_IDLE
    } rfs_state_e;

    // Nanoseconds to whole clock cycles, rounded up.
    function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned mhz);
        return (ns * mhz + 999) / 1000;
    endfunction

endpackage

// File: rtl/rfs_tick_timer.sv
module rfs_tick_timer #(
    parameter int unsigned PERIOD = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int unsigned CW = (PERIOD < 2) ? 1 : $clog2(PERIOD);

    logic [CW-1:0] cnt_q;

    assign tick = en && (cnt_q == CW'(PERIOD - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rfs_due_tracker.sv
module rfs_due_tracker (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic start,
    output logic pending,
    output logic overrun
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (tick) begin
                pending <= 1'b1;
            end else if (start) begin
                pending <= 1'b0;
            end
            if (tick && pending && !start) begin
                overrun <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rfs_cbr_fsm.sv
module rfs_cbr_fsm
    import rfs_pkg::*;
#(
    parameter int unsigned CSR_CYC     = 3,
    parameter int unsigned CHR_CYC     = 3,
    parameter int unsigned RASH_CYC    = 12,
    parameter int unsigned PRE_CYC     = 13,
    parameter int unsigned INIT_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pause_done,
    input  logic       pending,
    input  logic       gnt,
    output rfs_state_e state,
    output logic       ras_act,
    output logic       cas_act,
    output logic       start,
    output logic       ready
);
    localparam int unsigned MAX_A  = (CSR_CYC > CHR_CYC) ? CSR_CYC : CHR_CYC;
    localparam int unsigned MAX_B  = (RASH_CYC > PRE_CYC) ? RASH_CYC : PRE_CYC;
    localparam int unsigned MAX_PH = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned PW     = $clog2(MAX_PH + 1);
    localparam int unsigned IW     = $clog2(INIT_CYCLES + 1);

    rfs_state_e    state_q, state_d;
    logic [PW-1:0] ph_q, ph_d;
    logic [IW-1:0] init_q, init_d;
    logic          ready_q, ready_d;
    logic          ph_end;

    assign ph_end = (ph_q == '0);

    // Next state and phase counter
    always_comb begin
        state_d = state_q;
        ph_d    = ph_end ? ph_q : ph_q - 1'b1;
        init_d  = init_q;
        ready_d = ready_q;
        start   = 1'b0;
        unique case (state_q)
            ST_PAUSE: begin
                if (pause_done) begin
                    state_d = ST_CSR;
                    ph_d    = PW'(CSR_CYC - 1);
                end
            end
            ST_CSR: begin
                if (ph_end) begin
                    state_d = ST_CHR;
                    ph_d    = PW'(CHR_CYC - 1);
                end
            end
            ST_CHR: begin
                if (ph_end) begin
                    state_d = ST_RASH;
                    ph_d    = PW'(RASH_CYC - 1);
                end
            end
            ST_RASH: begin
                if (ph_end) begin
                    state_d = ST_PRE;
                    ph_d    = PW'(PRE_CYC - 1);
                end
            end
            ST_PRE: begin
                if (ph_end) begin
                    if (ready_q) begin
                        state_d = ST_IDLE;
                    end else if (init_q == IW'(INIT_CYCLES - 1)) begin
                        state_d = ST_IDLE;
                        ready_d = 1'b1;
                    end else begin
                        state_d = ST_CSR;
                        ph_d    = PW'(CSR_CYC - 1);
                        init_d  = init_q + 1'b1;
                    end
                end
            end
            ST_IDLE: begin
                if (pending && gnt) begin
                    state_d = ST_CSR;
                    ph_d    = PW'(CSR_CYC - 1);
                    start   = 1'b1;
                end
            end
            default: state_d = ST_PAUSE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PAUSE;
            ph_q    <= '0;
            init_q  <= '0;
            ready_q <= 1'b0;
        end else begin
            state_q <= state_d;
            ph_q    <= ph_d;
            init_q  <= init_d;
            ready_q <= ready_d;
        end
    end

    // Outputs decoded from the state register
    always_comb begin
        ras_act = 1'b0;
        cas_act = 1'b0;
        unique case (state_q)
            ST_CSR:  cas_act = 1'b1;
            ST_CHR:  begin cas_act = 1'b1; ras_act = 1'b1; end
            ST_RASH: ras_act = 1'b1;
            default: ;
        endcase
    end

    assign state = state_q;
    assign ready = ready_q;
endmodule

// File: rtl/rfs_cbr_refresh_top.sv
module rfs_cbr_refresh_top
    import rfs_pkg::*;
#(
    parameter int unsigned CLK_MHZ       = 250,
    parameter int unsigned PAUSE_US      = 200,
    parameter int unsigned REF_WINDOW_NS = 16_000_000,
    parameter int unsigned ROWS          = 1024,
    parameter int unsigned INIT_CYCLES   = 8,
    parameter int unsigned T_CSR_NS      = 10,
    parameter int unsigned T_CHR_NS      = 10,
    parameter int unsigned T_RAS_NS      = 60,
    parameter int unsigned T_RP_NS       = 40,
    parameter int unsigned T_RC_NS       = 110,
    parameter int unsigned NUM_RAS       = 2,
    parameter int unsigned NUM_CAS       = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ref_gnt,
    output logic               ref_req,
    output logic [NUM_RAS-1:0] ras_n,
    output logic [NUM_CAS-1:0] cas_n,
    output logic               we_n,
    output logic               ready,
    output logic               overrun
);
    localparam int unsigned PAUSE_CYC = PAUSE_US * CLK_MHZ;
    localparam int unsigned INTV_CYC  = (REF_WINDOW_NS / ROWS) * CLK_MHZ / 1000;
    localparam int unsigned CSR_CYC   = ns2cyc(T_CSR_NS, CLK_MHZ);
    localparam int unsigned CHR_CYC   = ns2cyc(T_CHR_NS, CLK_MHZ);
    localparam int unsigned RAS_CYC   = ns2cyc(T_RAS_NS, CLK_MHZ);
    localparam int unsigned RC_CYC    = ns2cyc(T_RC_NS, CLK_MHZ);
    localparam int unsigned RP_MIN    = ns2cyc(T_RP_NS, CLK_MHZ);
    localparam int unsigned RP_CYC    = (RC_CYC > RAS_CYC + RP_MIN) ? RC_CYC - RAS_CYC : RP_MIN;
    localparam int unsigned RASH_CYC  = (RAS_CYC > CHR_CYC) ? RAS_CYC - CHR_CYC : 1;

    rfs_state_e state;
    logic       pause_done, due_tick, pending, start;
    logic       ras_act, cas_act, busy;

    rfs_tick_timer #(.PERIOD(PAUSE_CYC)) pause_tmr_i (
        .clk (clk),
        .rst (rst),
        .en  (state == ST_PAUSE),
        .tick(pause_done)
    );

    rfs_tick_timer #(.PERIOD(INTV_CYC)) intv_tmr_i (
        .clk (clk),
        .rst (rst),
        .en  (ready),
        .tick(due_tick)
    );

    rfs_due_tracker due_i (
        .clk    (clk),
        .rst    (rst),
        .tick   (due_tick),
        .start  (start),
        .pending(pending),
        .overrun(overrun)
    );

    rfs_cbr_fsm #(
        .CSR_CYC    (CSR_CYC),
        .CHR_CYC    (CHR_CYC),
        .RASH_CYC   (RASH_CYC),
        .PRE_CYC    (RP_CYC),
        .INIT_CYCLES(INIT_CYCLES)
    ) fsm_i (
        .clk       (clk),
        .rst       (rst),
        .pause_done(pause_done),
        .pending   (pending),
        .gnt       (ref_gnt),
        .state     (state),
        .ras_act   (ras_act),
        .cas_act   (cas_act),
        .start     (start),
        .ready     (ready)
    );

    assign busy    = (state != ST_IDLE) && (state != ST_PAUSE);
    assign ref_req = ready && (pending || busy);
    assign we_n    = 1'b1;

    for (genvar gr = 0; gr < NUM_RAS; gr++) begin : g_ras
        assign ras_n[gr] = ~ras_act;
    end
    for (genvar gc = 0; gc < NUM_CAS; gc++) begin : g_cas
        assign cas_n[gc] = ~cas_act;
    end
endmodule

// File: rtl/rfs_cbr_refresh_chk.sv
module rfs_cbr_refresh_chk #(
    parameter int unsigned NUM_RAS = 2,
    parameter int unsigned NUM_CAS = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               ref_gnt,
    input logic               ref_req,
    input logic [NUM_RAS-1:0] ras_n,
    input logic [NUM_CAS-1:0] cas_n,
    input logic               ready,
    input logic               overrun
);
    assert_cas_leads_ras_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n[0]) |-> ($past(cas_n[0]) == 1'b0) && !cas_n[0]);

    assert_ready_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    assert_overrun_cause_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(ref_req));

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (ref_req && !ref_gnt) |=> ref_req);

    assert_quiet_strobes_R8: assert property (@(posedge clk) disable iff (rst)
        (ready && !ref_req) |-> ((&ras_n) && (&cas_n)));

    assert_start_on_grant_R9: assert property (@(posedge clk) disable iff (rst)
        (ready && $fell(cas_n[0])) |-> $past(ref_gnt && ref_req));
endmodule

bind rfs_cbr_refresh_top rfs_cbr_refresh_chk #(
    .NUM_RAS(NUM_RAS),
    .NUM_CAS(NUM_CAS)
) chk_i (
    .clk    (clk),
    .rst    (rst),
    .ref_gnt(ref_gnt),
    .ref_req(ref_req),
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .ready  (ready),
    .overrun(overrun)
);

// File: tb/rfs_cbr_refresh_top_tb_top.sv
`timescale 1ns/100ps
module rfs_cbr_refresh_top_tb_top;
    localparam int MHZ    = 250;
    localparam int PUS    = 2;
    localparam int WIN_NS = 1_024_000;
    localparam int NROWS  = 1024;
    localparam int NINIT  = 8;
    localparam int NR     = 2;
    localparam int NC     = 4;

    function automatic int cyc(input int ns);
        return (ns * MHZ + 999) / 1000;
    endfunction

    localparam int PAUSE_E = PUS * MHZ;
    localparam int INTV_E  = (WIN_NS / NROWS) * MHZ / 1000;
    localparam int LEAD_E  = cyc(10);
    localparam int CHR_E   = cyc(10);
    localparam int RAS_E   = cyc(60);
    localparam int PRE_E   = (cyc(110) - RAS_E > cyc(40)) ? cyc(110) - RAS_E : cyc(40);
    localparam int LEN_E   = LEAD_E + RAS_E + PRE_E;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ref_gnt = 1'b0;
    logic          ref_req;
    logic [NR-1:0] ras_n;
    logic [NC-1:0] cas_n;
    logic          we_n, ready, overrun;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    rfs_cbr_refresh_top #(
        .CLK_MHZ(MHZ), .PAUSE_US(PUS), .REF_WINDOW_NS(WIN_NS), .ROWS(NROWS),
        .INIT_CYCLES(NINIT), .NUM_RAS(NR), .NUM_CAS(NC)
    ) dut_i (
        .clk(clk), .rst(rst), .ref_gnt(ref_gnt), .ref_req(ref_req),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ready(ready), .overrun(overrun)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // Strobe monitor: measures every phase at the negedge
    int  mcyc = 0, cbr_count = 0;
    int  lead = 0, chr = 0, low_cnt = 0, high_cnt = 0, f2f = 0;
    bit  seen_fall = 0, seen_rise = 0;
    logic prev_r = 1'b1, prev_c = 1'b1;

    always @(negedge clk) begin
        if (rst) begin
            lead = 0; chr = 0; low_cnt = 0; high_cnt = 0; f2f = 0;
            seen_fall = 0; seen_rise = 0; prev_r = 1'b1; prev_c = 1'b1;
            cbr_count = 0;
        end else begin
            mcyc++;
            f2f++;
            if (prev_c && !cas_n[0]) lead = 0;
            if (!cas_n[0] && ras_n[0]) lead++;
            if (prev_r && !ras_n[0]) begin
                check(lead == LEAD_E && !cas_n[0], "R4 cas lead cycles", lead, LEAD_E);
                check(ras_n == '0 && cas_n == '0 && we_n, "R6 strobe group at ras fall",
                      int'({ras_n, cas_n, we_n}), 1);
                if (seen_rise) check(high_cnt * 4 >= 40, "R5 ras high ns", high_cnt * 4, 40);
                if (seen_fall) check(f2f * 4 >= 110, "R5 ras fall-to-fall ns", f2f * 4, 110);
                f2f = 0; low_cnt = 0; chr = 0; seen_fall = 1;
                cbr_count++;
            end
            if (!prev_c && cas_n[0] && !ras_n[0])
                check(chr == CHR_E, "R4 cas hold after ras fall", chr, CHR_E);
            if (!prev_r && ras_n[0]) begin
                check(low_cnt == RAS_E, "R5 ras low cycles", low_cnt, RAS_E);
                high_cnt = 0; seen_rise = 1;
            end
            if (!ras_n[0]) begin
                low_cnt++;
                if (!cas_n[0]) chr++;
            end else begin
                high_cnt++;
            end
            prev_r = ras_n[0];
            prev_c = cas_n[0];
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        ref_gnt = 1'b0;
        repeat (3) step();
        check(ras_n == '1 && cas_n == '1 && we_n && !ready && !ref_req && !overrun,
              "R1 outputs in reset", int'({ras_n, cas_n, ready, ref_req, overrun}), 'h3f << 3);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        step();
        check(ras_n == '1 && cas_n == '1 && !ready && !ref_req && !overrun,
              "R1 first cycle after reset", int'({ras_n, cas_n, ready, ref_req, overrun}), 'h3f << 3);
    endtask

    task automatic t_pause();
        int n = 1;
        bit early = 0;
        while (n < PAUSE_E + 50 && cas_n[0]) begin
            if (ras_n != '1) early = 1;
            step();
            n++;
        end
        check(n == PAUSE_E, "R2 edges to first CAS fall", n, PAUSE_E);
        check(!early, "R2 no RAS during pause", early, 0);
    endtask

    task automatic t_init();
        int n = 0;
        bit req_seen = 0;
        while (n < NINIT * LEN_E + 50 && !ready) begin
            step();
            n++;
            if (ref_req) req_seen = 1;
        end
        check(n == NINIT * LEN_E, "R3 edges from first CAS to ready", n, NINIT * LEN_E);
        check(cbr_count == NINIT, "R3 init cycle count", cbr_count, NINIT);
        check(!req_seen, "R3 no request during init", req_seen, 0);
    endtask

    task automatic t_request_hold();
        int n = 0;
        bit bad = 0;
        while (n < INTV_E + 50 && !ref_req) begin
            step();
            n++;
        end
        check(n == INTV_E, "R7 edges from ready to request", n, INTV_E);
        repeat (100) begin
            step();
            if (!ref_req || ras_n != '1 || cas_n != '1) bad = 1;
        end
        check(!bad, "R8 request held, strobes idle without grant", bad, 0);
        ref_gnt = 1'b1;
        step();
        check(cas_n == '0 && ras_n == '1, "R9 CAS falls on edge after grant", int'(cas_n), 0);
        n = 0;
        while (n < LEN_E + 50 && ref_req) begin
            step();
            n++;
        end
        check(n == LEN_E, "R9 request drop after start", n, LEN_E);
        ref_gnt = 1'b0;
        check(!overrun && ready, "R10 no overrun when served in time", int'(overrun), 0);
    endtask

    task automatic t_periodic();
        int c0, t1 = 0, t2 = 0, t3 = 0, guard = 0;
        ref_gnt = 1'b1;
        c0 = cbr_count;
        while (cbr_count < c0 + 3 && guard < 4 * INTV_E) begin
            step();
            guard++;
            if (cbr_count == c0 + 1 && t1 == 0) t1 = mcyc;
            if (cbr_count == c0 + 2 && t2 == 0) t2 = mcyc;
            if (cbr_count == c0 + 3 && t3 == 0) t3 = mcyc;
        end
        check(t2 - t1 == INTV_E, "R7 refresh spacing 1", t2 - t1, INTV_E);
        check(t3 - t2 == INTV_E, "R7 refresh spacing 2", t3 - t2, INTV_E);
        check(!overrun, "R10 no overrun with grant held", int'(overrun), 0);
        while (ref_req && guard < 5 * INTV_E) begin
            step();
            guard++;
        end
        ref_gnt = 1'b0;
    endtask

    task automatic t_overrun();
        int n = 0;
        while (n < INTV_E + 50 && !ref_req) begin
            step();
            n++;
        end
        repeat (INTV_E + 5) step();
        check(overrun, "R10 overrun after missed interval", int'(overrun), 1);
        check(ready, "R11 ready stays high", int'(ready), 1);
        ref_gnt = 1'b1;
        step();
        n = 0;
        while (n < LEN_E + 50 && ref_req) begin
            step();
            n++;
        end
        ref_gnt = 1'b0;
        step();
        check(overrun, "R10 overrun sticky after service", int'(overrun), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        t_reset_state();
        t_pause();
        t_init();
        t_request_hold();
        t_periodic();
        t_overrun();
        do_reset();
        step();
        check(!overrun && !ready, "R10 overrun cleared by reset",
              int'({overrun, ready}), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule